// File: doc/BRIEF.md
# Audio Activity Standby Detector

This block watches a stream of stereo audio samples and decides whether the amplifier path should be in its normal active state or in a low-power standby state. For each valid sample it takes the larger of the two channel magnitudes and compares it with a programmable threshold. A run of quiet samples, counted in valid strobes, that reaches a programmable limit moves the block into standby. The first loud sample then brings it straight back to active.

The mode is a registered level output. A one-cycle strobe marks each entry into standby and each return to active, so that power-management logic can react to the change. The block does not gate any power itself.

Top module: `aad_standby_detector`

## Requirements
- R1: After a synchronous active-high reset the block is active, with `standby` low, both pulses low and the quiet count cleared.
- R2: Samples are signed two's complement. The level is max(|left|, |right|), and the most negative code has magnitude 2^(SAMPLE_W-1). A sample is loud when its level is strictly greater than `level_thresh`. A level equal to the threshold is quiet.
- R3: While active, the valid quiet sample that makes the number of consecutive quiet valid samples reach `idle_limit` moves the block to standby at that clock edge. An `idle_limit` of 0 acts as 1.
- R4: While active, a loud valid sample clears the quiet count, so a full new run of `idle_limit` quiet samples is then needed.
- R5: While in standby, the first loud valid sample returns the block to active at that clock edge. The quiet count then restarts from zero.
- R6: `enter_pulse` is high for exactly the first cycle in which `standby` is high. `exit_pulse` is high for exactly the first cycle in which `standby` is low after standby. The two are never high together.
- R7: Cycles with `smp_vld` low change neither the mode nor the quiet count, and raise no pulse.
- R8: Quiet valid samples received in standby keep the block in standby and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe |
| smp_left | input | SAMPLE_W | Left sample, signed |
| smp_right | input | SAMPLE_W | Right sample, signed |
| level_thresh | input | SAMPLE_W | Magnitude threshold, unsigned |
| idle_limit | input | CNT_W | Number of quiet samples before standby |
| standby | output | 1 | High while in standby |
| enter_pulse | output | 1 | One-cycle strobe on entering standby |
| exit_pulse | output | 1 | One-cycle strobe on leaving standby |

## Verification
The assertions check the following on every cycle:
- a loud sample in standby always wakes the block;
- a loud sample in active always clears the count;
- idle cycles leave the mode and the count untouched;
- each pulse lines up with its edge of `standby`, and the two pulses never overlap.

Other behaviours are shown only by the bench's scenarios, which it compares against a reference model:
- the exact sample on which standby is entered;
- the threshold-equality boundary;
- the magnitude of the most negative code;
- the zero limit.

// File: rtl/aad_pkg.sv
package aad_pkg;
  typedef enum logic {
    MODE_ACTIVE  = 1'b0,
    MODE_STANDBY = 1'b1
  } aad_mode_e;
endpackage

// File: rtl/aad_level.sv
module aad_level #(
  parameter int SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic [SAMPLE_W-1:0] level_thresh,
  output logic                loud
);
  logic [SAMPLE_W-1:0] mag_l, mag_r, peak;

  // Two's complement magnitude. The most negative code maps to 2^(W-1) unsigned (R2).
  always_comb begin
    mag_l = smp_left[SAMPLE_W-1]  ? (~smp_left  + 1'b1) : smp_left;
    mag_r = smp_right[SAMPLE_W-1] ? (~smp_right + 1'b1) : smp_right;
    peak  = (mag_l > mag_r) ? mag_l : mag_r;
    loud  = peak > level_thresh;
  end
endmodule

// File: rtl/aad_quiet_cnt.sv
module aad_quiet_cnt #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic             loud,
  input  logic             active,
  input  logic [CNT_W-1:0] idle_limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    // A limit of 0 is always met, so it acts as 1 (R3).
    expire  = smp_vld && !loud && active && (cnt_inc >= {1'b0, idle_limit});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (smp_vld) begin
      if (!active || loud || expire) cnt_q <= '0;
      else                           cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end

  p_loud_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && loud && active) |=> (cnt_q == '0));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> $stable(cnt_q));
endmodule

// File: rtl/aad_mode_fsm.sv
module aad_mode_fsm
  import aad_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic smp_vld,
  input  logic loud,
  input  logic expire,
  output logic active,
  output logic standby,
  output logic enter_pulse,
  output logic exit_pulse
);
  aad_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_ACTIVE:  if (expire)            mode_d = MODE_STANDBY;
      MODE_STANDBY: if (smp_vld && loud)   mode_d = MODE_ACTIVE;
      default:                             mode_d = MODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_ACTIVE;
      enter_pulse <= 1'b0;
      exit_pulse  <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      enter_pulse <= (mode_q == MODE_ACTIVE)  && (mode_d == MODE_STANDBY);
      exit_pulse  <= (mode_q == MODE_STANDBY) && (mode_d == MODE_ACTIVE);
    end
  end

  assign active  = (mode_q == MODE_ACTIVE);
  assign standby = (mode_q == MODE_STANDBY);

  p_wake_r5: assert property (@(posedge clk) disable iff (rst)
    (standby && smp_vld && loud) |=> !standby);
  p_idle_mode_r7: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(standby) && !enter_pulse && !exit_pulse));
  p_enter_edge_r6: assert property (@(posedge clk) disable iff (rst)
    enter_pulse |-> (standby && !$past(standby)));
  p_exit_edge_r6: assert property (@(posedge clk) disable iff (rst)
    exit_pulse |-> (!standby && $past(standby)));
  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(enter_pulse && exit_pulse));
endmodule

// File: rtl/aad_standby_detector.sv
module aad_standby_detector #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic [SAMPLE_W-1:0] level_thresh,
  input  logic [CNT_W-1:0]    idle_limit,
  output logic                standby,
  output logic                enter_pulse,
  output logic                exit_pulse
);
  logic loud, expire, active;

  aad_level #(.SAMPLE_W(SAMPLE_W)) level_i (
    .smp_left(smp_left), .smp_right(smp_right),
    .level_thresh(level_thresh), .loud(loud)
  );

  aad_quiet_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .loud(loud),
    .active(active), .idle_limit(idle_limit), .expire(expire)
  );

  aad_mode_fsm fsm_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .loud(loud), .expire(expire),
    .active(active), .standby(standby),
    .enter_pulse(enter_pulse), .exit_pulse(exit_pulse)
  );

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!standby && !enter_pulse && !exit_pulse));
endmodule

// File: tb/aad_standby_detector_tb_top.sv
module aad_standby_detector_tb_top;
  localparam int SW = 24;
  localparam int CW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic [SW-1:0] smp_left = '0, smp_right = '0, level_thresh = '0;
  logic [CW-1:0] idle_limit = '0;
  logic standby, enter_pulse, exit_pulse;

  int checks = 0;
  int errors = 0;
  bit m_sb = 0;
  int m_cnt = 0;
  bit m_ent = 0, m_ex = 0;
  bit done = 0;

  always #4 clk = ~clk;

  aad_standby_detector #(.SAMPLE_W(SW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_left(smp_left),
    .smp_right(smp_right), .level_thresh(level_thresh), .idle_limit(idle_limit),
    .standby(standby), .enter_pulse(enter_pulse), .exit_pulse(exit_pulse)
  );

  function automatic longint mag(input logic [SW-1:0] v);
    longint s = longint'($signed(v));
    return (s < 0) ? -s : s;
  endfunction

  function automatic bit is_loud(input logic [SW-1:0] l, input logic [SW-1:0] r,
                                 input logic [SW-1:0] th);
    longint m = (mag(l) > mag(r)) ? mag(l) : mag(r);
    return m > longint'(th);
  endfunction

  task automatic check(input string tag);
    checks++;
    if (standby !== m_sb || enter_pulse !== m_ent || exit_pulse !== m_ex) begin
      errors++;
      $display("FAIL %s: sb/ent/ex actual %b%b%b expected %b%b%b",
               tag, standby, enter_pulse, exit_pulse, m_sb, m_ent, m_ex);
    end
  endtask

  task automatic step(input bit v, input logic [SW-1:0] l, input logic [SW-1:0] r,
                      input string tag, input bit do_chk);
    int lim;
    @(negedge clk);
    smp_vld = v; smp_left = l; smp_right = r;
    m_ent = 0; m_ex = 0;
    lim = (idle_limit == 0) ? 1 : int'(idle_limit);
    if (v) begin
      if (!m_sb) begin
        if (is_loud(l, r, level_thresh)) m_cnt = 0;
        else if (m_cnt + 1 >= lim) begin m_sb = 1; m_ent = 1; m_cnt = 0; end
        else m_cnt++;
      end else if (is_loud(l, r, level_thresh)) begin
        m_sb = 0; m_ex = 1; m_cnt = 0;
      end
    end
    @(posedge clk); #1;
    if (do_chk) check(tag);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7421));
    level_thresh = 24'd100; idle_limit = 20'd3;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    #1; check("R1 reset");

    // R3: third quiet sample enters standby; equality to threshold is quiet (R2)
    step(1, 24'd100, -24'sd100, "R2 equal is quiet", 1);
    step(1, 24'd5, 24'd0, "R3 count", 1);
    step(0, 24'd900, 24'd900, "R7 idle in active", 1);
    step(1, 24'd0, 24'd0, "R3 enter on limit", 1);
    step(1, 24'd0, 24'd0, "R6 enter pulse single", 1);
    step(1, 24'd50, -24'sd60, "R8 quiet in standby", 1);
    step(0, 24'd900, 24'd0, "R7 idle in standby", 1);
    // R2/R5: right channel loud via negative value
    step(1, 24'd0, -24'sd101, "R5 wake on right negative", 1);
    step(1, 24'd0, 24'd0, "R6 exit pulse single", 1);
    // R4: loud resets count mid-run
    step(1, 24'd0, 24'd0, "R4 quiet", 1);
    step(1, 24'd101, 24'd0, "R4 loud clears", 1);
    step(1, 24'd0, 24'd0, "R4 quiet 1", 1);
    step(1, 24'd0, 24'd0, "R4 quiet 2 no entry", 1);
    step(1, 24'd0, 24'd0, "R3 entry after fresh run", 1);
    // R2: most negative code is maximal magnitude
    level_thresh = 24'h7FFFFF;
    step(1, 24'h800000, 24'd0, "R2 most negative loud", 1);
    // R3: limit 0 acts as 1
    idle_limit = 20'd0;
    step(1, 24'h7FFFFF, 24'd0, "R3 limit zero", 1);
    step(1, 24'h800000, 24'd0, "R5 wake", 1);

    // Randomised mix
    for (int i = 0; i < 4000; i++) begin
      logic [SW-1:0] l, r;
      if (i % 500 == 0) begin
        level_thresh = 24'($urandom_range(0, 2000));
        idle_limit   = 20'($urandom_range(0, 8));
      end
      if ($urandom_range(0, 9) < 8) begin
        l = 24'($signed(int'($urandom_range(0, 2 * int'(level_thresh))) - int'(level_thresh)));
        r = 24'($signed(int'($urandom_range(0, 2 * int'(level_thresh))) - int'(level_thresh)));
      end else begin
        l = 24'($urandom); r = 24'($urandom);
      end
      step($urandom_range(0, 3) != 0, l, r, "R3 R4 R5 R6 R8 random", 1);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule